// File: doc/BRIEF.md
# UART FIFO DMA Request Controller

This block is the per-channel DMA handshake logic that sits between a host DMA engine and the 128-byte transmit and receive FIFOs of one UART channel. It watches the FIFO fill levels and the programmed transmit trigger level, and it raises one transmit request and one receive request. Each request stays up until the DMA controller sends a terminal-count pulse or the FIFO reaches the level that makes the transfer pointless.

The block also recognises DMA bus cycles. While the acknowledge input is low and the address-enable input is high, host write strobes become pushes into the TX FIFO and read strobes become pops from the RX FIFO. Register address and chip select play no part in such a cycle. Outside a DMA cycle, strobes with chip select asserted pass through as ordinary register accesses.

When DMA is disabled for a direction, that direction's request pin gives the active-low ready status instead. The FIFO storage and the serial engine are not part of the block. Only their fill levels come in.

Top module: `uart_dma_ctrl`

## Requirements
- R1: A DMA cycle is present exactly when `dack_n` is 0 and `aen` is 1. In such a cycle `wr_stb` produces `tx_push` and `rd_stb` produces `rx_pop` in the same cycle (combinational). `reg_wr` and `reg_rd` stay 0 whatever `cs_n` and `addr` are.
- R2: Outside a DMA cycle, `reg_wr` equals `wr_stb` and `reg_rd` equals `rd_stb` when `cs_n` is 0, and both are 0 when `cs_n` is 1. `reg_addr` always equals `addr`, and `tx_push` and `rx_pop` are 0.
- R3: With TX DMA enabled, `tx_req_pin` goes to 1 on the clock edge after `tx_level <= tx_trig` becomes true. It then stays 1 until `tx_level > tx_trig` or `tc` is sampled high, and it drops on that edge.
- R4: With RX DMA enabled, `rx_req_pin` goes to 1 on the clock edge after `rx_level` becomes non-zero. It then stays 1 until `rx_level` is 0 or `tc` is sampled high, and it drops on that edge.
- R5: A `tc` high sampled at an edge clears both requests on that edge. A cleared request is not raised again while its start condition stays true. It is raised again on the edge after the condition goes false and then true again.
- R6: Turning a direction's DMA enable on while its start condition is already true raises that request on the next edge. Turning the enable off clears the request.
- R7: With TX DMA disabled, `tx_req_pin` is 1 when `tx_level` equals 128 and 0 otherwise. With RX DMA disabled, `rx_req_pin` is 1 when `rx_level` is 0 and 0 otherwise. Both are combinational.
- R8: A DMA write while `tx_level` is 128 gives no `tx_push` and sets `tx_ovf` on the next edge. A DMA read while `rx_level` is 0 gives no `rx_pop` and sets `rx_unf` on the next edge. Both flags stay set until reset.
- R9: After reset, both request pins show their ready status until a start condition is seen, and `tx_ovf` and `rx_unf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_trig | input | 8 | TX FIFO trigger level (0..128) |
| tx_level | input | 8 | TX FIFO fill level (0..128) |
| rx_level | input | 8 | RX FIFO fill level (0..128) |
| dack_n | input | 1 | DMA acknowledge, active low |
| aen | input | 1 | DMA address enable, active high |
| tc | input | 1 | DMA terminal count pulse |
| cs_n | input | 1 | Channel chip select, active low |
| addr | input | 3 | Register address |
| wr_stb | input | 1 | Host write strobe (one cycle per byte) |
| rd_stb | input | 1 | Host read strobe (one cycle per byte) |
| tx_push | output | 1 | Push the bus byte into the TX FIFO |
| rx_pop | output | 1 | Pop a byte from the RX FIFO onto the bus |
| reg_wr | output | 1 | Register write to the channel register file |
| reg_rd | output | 1 | Register read from the channel register file |
| reg_addr | output | 3 | Register address to the register file |
| tx_req_pin | output | 1 | TX DMA request, or TX ready (active low) when disabled |
| rx_req_pin | output | 1 | RX DMA request, or RX ready (active low) when disabled |
| tx_ovf | output | 1 | Sticky: DMA write hit a full TX FIFO |
| rx_unf | output | 1 | Sticky: DMA read hit an empty RX FIFO |

## Verification
The routing is swept over every mix of acknowledge, address enable, chip select and the two strobes, against a full and a non-full TX FIFO and an empty and a non-empty RX FIFO. This separates DMA routing from register decoding and from the full/empty blocking. The request logic is driven with fill levels that ramp up through the whole 0..128 range and back down, at trigger levels 0, 1, 64, 127 and 128. Terminal-count pulses and enable drop-outs are mixed in along the ramps, which exposes off-by-one errors at the trigger boundary and shows whether a cleared request re-arms only on a new start. Directed sequences then pin down terminal-count suppression, raising on enable, and the sticky error flags together with their reset.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    // Request tracker state: live request and last-cycle start condition
    typedef struct packed {
        logic req;
        logic armed;
    } req_state_t;

    // Sticky DMA error flags
    typedef struct packed {
        logic ovf;
        logic unf;
    } err_state_t;

endpackage

// File: rtl/uart_dma_route.sv
module uart_dma_route
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = 3,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dack_n,
    input  logic             aen,
    input  logic             cs_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output logic             dma_cycle,
    output logic             tx_push,
    output logic             rx_pop,
    output logic             reg_wr,
    output logic             reg_rd,
    output logic [AW-1:0]    reg_addr,
    output logic             tx_ovf,
    output logic             rx_unf
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    err_state_t err_d, err_q;
    logic       tx_full, rx_empty;
    logic       bad_wr, bad_rd;

    always_comb begin
        dma_cycle = !dack_n && aen;
        tx_full   = (tx_level >= FULL_LVL);
        rx_empty  = (rx_level == '0);
        tx_push   = dma_cycle && wr_stb && !tx_full;
        rx_pop    = dma_cycle && rd_stb && !rx_empty;
        bad_wr    = dma_cycle && wr_stb && tx_full;
        bad_rd    = dma_cycle && rd_stb && rx_empty;
        reg_wr    = !dma_cycle && !cs_n && wr_stb;
        reg_rd    = !dma_cycle && !cs_n && rd_stb;
        reg_addr  = addr;

        err_d     = err_q;
        if (bad_wr) err_d.ovf = 1'b1;
        if (bad_rd) err_d.unf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign tx_ovf = err_q.ovf;
    assign rx_unf = err_q.unf;

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);
    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_unf |=> rx_unf);
    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_cycle && wr_stb && tx_level == FULL_LVL) |=> tx_ovf);

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter bit IS_TX = 1'b1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tc,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    output logic             req_pin
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    req_state_t st_d, st_q;
    logic       start;
    logic       rdy_n;

    // Direction variant: start condition and ready-status polarity
    generate
        if (IS_TX) begin : g_tx
            assign start = (level <= trig);
            assign rdy_n = (level == FULL_LVL);
        end else begin : g_rx
            logic unused_trig;
            assign unused_trig = ^trig;
            assign start = (level != '0);
            assign rdy_n = (level == '0);
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.armed = en && start;
        st_d.req   = en && !tc && start && (!st_q.armed || st_q.req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_pin = en ? st_q.req : rdy_n;

    // R5
    tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !st_q.req);
    // R3 R4 R6
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> ($past(start) && $past(en)));
    // R3 R4
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.req) |-> ($past(tc) || !$past(start) || !$past(en)));

endmodule

// File: rtl/uart_dma_ctrl.sv
module uart_dma_ctrl
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = 3,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             dack_n,
    input  logic             aen,
    input  logic             tc,
    input  logic             cs_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_stb,
    input  logic             rd_stb,
    output logic             tx_push,
    output logic             rx_pop,
    output logic             reg_wr,
    output logic             reg_rd,
    output logic [AW-1:0]    reg_addr,
    output logic             tx_req_pin,
    output logic             rx_req_pin,
    output logic             tx_ovf,
    output logic             rx_unf
);

    logic dma_cycle;

    uart_dma_route #(.DEPTH(DEPTH), .AW(AW)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .dack_n   (dack_n),
        .aen      (aen),
        .cs_n     (cs_n),
        .addr     (addr),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .dma_cycle(dma_cycle),
        .tx_push  (tx_push),
        .rx_pop   (rx_pop),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .tx_ovf   (tx_ovf),
        .rx_unf   (rx_unf)
    );

    uart_dma_req #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tx_dma_en),
        .tc     (tc),
        .level  (tx_level),
        .trig   (tx_trig),
        .req_pin(tx_req_pin)
    );

    uart_dma_req #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rx_dma_en),
        .tc     (tc),
        .level  (rx_level),
        .trig   (tx_trig),
        .req_pin(rx_req_pin)
    );

    // R1
    dma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dack_n && aen) |-> (!reg_wr && !reg_rd));
    // R2
    no_push_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_cycle |-> (!tx_push && !rx_pop));

endmodule

// File: tb/sim_uart_dma_ctrl.sv
module sim_uart_dma_ctrl;

    localparam int CLK_P = 10;
    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_dma_en, rx_dma_en;
    logic [7:0] tx_trig, tx_level, rx_level;
    logic       dack_n, aen, tc, cs_n, wr_stb, rd_stb;
    logic [2:0] addr;
    logic       tx_push, rx_pop, reg_wr, reg_rd;
    logic [2:0] reg_addr;
    logic       tx_req_pin, rx_req_pin, tx_ovf, rx_unf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference request model state
    logic m_txreq, m_txarm, m_rxreq, m_rxarm;

    always #(CLK_P/2) clk = ~clk;

    uart_dma_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_trig(tx_trig), .tx_level(tx_level), .rx_level(rx_level),
        .dack_n(dack_n), .aen(aen), .tc(tc), .cs_n(cs_n), .addr(addr),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .tx_push(tx_push), .rx_pop(rx_pop),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .tx_req_pin(tx_req_pin), .rx_req_pin(rx_req_pin),
        .tx_ovf(tx_ovf), .rx_unf(rx_unf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tx_dma_en = 0; rx_dma_en = 0; tx_trig = 8'd16;
        tx_level = 8'd0; rx_level = 8'd0;
        dack_n = 1; aen = 0; tc = 0; cs_n = 1; wr_stb = 0; rd_stb = 0; addr = 3'd0;
        m_txreq = 0; m_txarm = 0; m_rxreq = 0; m_rxarm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle of request activity: drive at negedge, check pins, advance model
    task automatic req_cyc(input logic ten, input logic ren, input logic t,
                           input int tl, input int rl, input int trg);
        logic ts, rs;
        @(negedge clk);
        tx_dma_en = ten; rx_dma_en = ren; tc = t;
        tx_level = 8'(tl); rx_level = 8'(rl); tx_trig = 8'(trg);
        #1;
        if (ten) chk("R3/R5 tx request", {31'd0, tx_req_pin}, {31'd0, m_txreq});
        else     chk("R7 tx ready", {31'd0, tx_req_pin}, {31'd0, (tl == DEPTH)});
        if (ren) chk("R4/R5 rx request", {31'd0, rx_req_pin}, {31'd0, m_rxreq});
        else     chk("R7 rx ready", {31'd0, rx_req_pin}, {31'd0, (rl == 0)});
        ts = (tl <= trg);
        rs = (rl != 0);
        m_txreq = ten && !t && ts && (!m_txarm || m_txreq);
        m_txarm = ten && ts;
        m_rxreq = ren && !t && rs && (!m_rxarm || m_rxreq);
        m_rxarm = ren && rs;
    endtask

    initial begin : watchdog
        #(CLK_P * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic exp_ovf, exp_unf;
        do_reset();

        // R9: reset state
        #1;
        chk("R9 tx_ovf", {31'd0, tx_ovf}, 0);
        chk("R9 rx_unf", {31'd0, rx_unf}, 0);
        chk("R9 tx pin ready", {31'd0, tx_req_pin}, 0);
        chk("R9 rx pin ready", {31'd0, rx_req_pin}, 1);

        // R1 R2 R8: exhaustive routing sweep
        exp_ovf = 0; exp_unf = 0;
        for (int lv = 0; lv < 2; lv++) begin
            for (int i = 0; i < 32; i++) begin
                logic dma, full, empty;
                @(negedge clk);
                dack_n = i[0]; aen = i[1]; cs_n = i[2]; wr_stb = i[3]; rd_stb = i[4];
                addr = 3'(i + lv);
                tx_level = lv ? 8'd128 : 8'd5;
                rx_level = lv ? 8'd0 : 8'd3;
                full = (lv == 1); empty = (lv == 1);
                dma = !i[0] && i[1];
                #1;
                chk("R1 tx_push", {31'd0, tx_push}, {31'd0, dma && i[3] && !full});
                chk("R1 rx_pop", {31'd0, rx_pop}, {31'd0, dma && i[4] && !empty});
                chk("R2 reg_wr", {31'd0, reg_wr}, {31'd0, !dma && !i[2] && i[3]});
                chk("R2 reg_rd", {31'd0, reg_rd}, {31'd0, !dma && !i[2] && i[4]});
                chk("R2 reg_addr", {29'd0, reg_addr}, {29'd0, 3'(i + lv)});
                chk("R8 tx_ovf", {31'd0, tx_ovf}, {31'd0, exp_ovf});
                chk("R8 rx_unf", {31'd0, rx_unf}, {31'd0, exp_unf});
                exp_ovf = exp_ovf || (dma && i[3] && full);
                exp_unf = exp_unf || (dma && i[4] && empty);
            end
        end
        @(negedge clk);
        dack_n = 1; aen = 0; wr_stb = 0; rd_stb = 0; cs_n = 1;
        #1;
        chk("R8 tx_ovf held", {31'd0, tx_ovf}, 1);
        chk("R8 rx_unf held", {31'd0, rx_unf}, 1);

        // R9: reset clears the sticky flags
        do_reset();
        #1;
        chk("R9 tx_ovf cleared", {31'd0, tx_ovf}, 0);
        chk("R9 rx_unf cleared", {31'd0, rx_unf}, 0);

        // R3 R4 R5 R6 R7: ramp sweeps over trigger levels
        for (int k = 0; k < 5; k++) begin
            int trg, n;
            case (k)
                0: trg = 0;
                1: trg = 1;
                2: trg = 64;
                3: trg = 127;
                default: trg = 128;
            endcase
            n = 0;
            for (int dir = 0; dir < 2; dir++) begin
                for (int s = 0; s <= DEPTH; s++) begin
                    int lvl;
                    logic en_t, tc_t;
                    lvl  = dir ? (DEPTH - s) : s;
                    en_t = (n % 50) < 44;
                    tc_t = (n % 37) == 20;
                    req_cyc(en_t, en_t, tc_t, DEPTH - lvl, lvl, trg);
                    n++;
                end
            end
        end

        // R5: terminal count suppresses re-raise while condition holds
        do_reset();
        req_cyc(1, 1, 0, 0, 4, 10);
        req_cyc(1, 1, 0, 0, 4, 10);
        chk("R3 tx req raised", {31'd0, tx_req_pin}, 1);
        chk("R4 rx req raised", {31'd0, rx_req_pin}, 1);
        req_cyc(1, 1, 1, 0, 4, 10);
        req_cyc(1, 1, 0, 0, 4, 10);
        chk("R5 tx cleared by tc", {31'd0, tx_req_pin}, 0);
        chk("R5 rx cleared by tc", {31'd0, rx_req_pin}, 0);
        req_cyc(1, 1, 0, 0, 4, 10);
        chk("R5 tx not re-raised", {31'd0, tx_req_pin}, 0);
        chk("R5 rx not re-raised", {31'd0, rx_req_pin}, 0);
        req_cyc(1, 1, 0, 11, 0, 10);
        req_cyc(1, 1, 0, 10, 1, 10);
        req_cyc(1, 1, 0, 10, 1, 10);
        chk("R5 tx re-raised on new start", {31'd0, tx_req_pin}, 1);
        chk("R5 rx re-raised on new start", {31'd0, rx_req_pin}, 1);

        // R6: disable shows ready status; enable re-raises next edge
        req_cyc(0, 0, 0, 10, 1, 10);
        chk("R6 tx disabled ready", {31'd0, tx_req_pin}, 0);
        chk("R6 rx disabled ready", {31'd0, rx_req_pin}, 0);
        req_cyc(1, 1, 0, 10, 1, 10);
        chk("R6 tx low same cycle as enable", {31'd0, tx_req_pin}, 0);
        req_cyc(1, 1, 0, 10, 1, 10);
        chk("R6 tx raised after enable", {31'd0, tx_req_pin}, 1);
        chk("R6 rx raised after enable", {31'd0, rx_req_pin}, 1);

        // R7: full TX and empty RX ready status with DMA off
        req_cyc(0, 0, 0, 128, 0, 10);
        chk("R7 tx full not ready", {31'd0, tx_req_pin}, 1);
        chk("R7 rx empty not ready", {31'd0, rx_req_pin}, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule